// File: doc/BRIEF.md
# Three-Device Polling Scheduler

This block decides in which order three devices are serviced, based on each device's status byte. It examines one device per clock cycle in a fixed order. When it finds a device that is ready, it issues a one-hot grant to that device and holds the grant until a service-done pulse arrives. It never moves on while a grant is outstanding. The transfer itself happens outside this block.

A run begins with a start pulse while the block is idle. The discipline for the whole run is sampled at that moment:

- **Fixed priority:** after each service the scan goes back to device 1.
- **Round robin:** after a service the scan carries on with the next device in the order.

A termination request stops the run. Once it has been seen, scanning ends at the next point where the discipline checks for termination. The block then raises a finished indication and returns to idle.

Top module: `poll_sched3`

## Requirements
- R1: After reset the block is idle: `grant` is 0 and `finished` is 0, whatever the status bytes are, until a start pulse arrives.
- R2: A device counts as ready only when bit 5 of its status byte is 1. The other seven bits have no effect on any grant.
- R3: At most one grant bit is 1 at any time. A grant that is asserted stays unchanged until `svc_done` is sampled high.
- R4: Devices are examined one per cycle in the order 1, 2, 3 (grant bits 0, 1, 2). The first ready device found is granted.
- R5: In fixed-priority mode (`mode`=0), the device examined right after a completed service is device 1.
- R6: In round-robin mode (`mode`=1), the device examined after a completed service of device k is device k+1. Device 1 follows device 3.
- R7: In fixed-priority mode, termination is checked after every completed service and after device 3 is examined and found not ready. If a termination request has been seen, the run ends: `finished` becomes 1 and no further grant is issued.
- R8: In round-robin mode, termination is checked only when the scan leaves device 3. Ready devices 2 and 3 are still served in the current pass after a termination request.
- R9: While no device is ready and no termination has been requested, the scan repeats without end: no grant and no finish.
- R10: `mode` is sampled only at the start pulse. Changing it during a run has no effect on that run.
- R11: `svc_done` while no grant is asserted, and `start` while a run is in progress, are ignored.
- R12: `finished` stays 1 until the next start pulse. That pulse clears `finished` and the stored termination request, and begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| mode | input | 1 | Discipline: 0 = fixed priority, 1 = round robin |
| dev_status | input | 24 | Status bytes; device 1 in bits 7:0, device 2 in bits 15:8, device 3 in bits 23:16 |
| svc_done | input | 1 | One-cycle pulse: the granted device has finished its service |
| term_req | input | 1 | Termination request; held internally once seen |
| grant | output | 3 | One-hot service grant; bit 0 = device 1 |
| finished | output | 1 | High once a run has terminated, until the next start |

## Verification
The bench keeps all three devices ready and uses `svc_done` pulses to steer which device becomes ready again. A design that mixed up the two disciplines would therefore grant device 3 where device 1 is due, or device 1 where device 3 is due.

Termination is requested in the middle of a round-robin pass, so a design that stops at the first service check would miss the grants to devices 2 and 3.

The bench flips `mode` mid-run and pulses `start` and `svc_done` at moments when they must be ignored. A design that latched them would show a changed order or a dropped grant. Status bytes with every bit set except bit 5 expose a design that tests the wrong bit.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_SERVE = 2'd2
  } pscan_state_e;

  typedef enum logic {
    DISC_PRIO = 1'b0,
    DISC_RR   = 1'b1
  } pscan_disc_e;
endpackage

// File: rtl/pscan_ready_extract.sv
module pscan_ready_extract #(
  parameter int N_DEV   = 3,
  parameter int STAT_W  = 8,
  parameter int RDY_BIT = 5
) (
  input  logic [N_DEV*STAT_W-1:0] status_i,
  output logic [N_DEV-1:0]        rdy_o
);
  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_dev
      assign rdy_o[g] = status_i[g*STAT_W + RDY_BIT];
    end
  endgenerate
endmodule

// File: rtl/pscan_step.sv
module pscan_step
  import pscan_pkg::*;
#(
  parameter int N_DEV = 3,
  localparam int IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [IW-1:0] idx_i,
  input  pscan_disc_e   disc_i,
  input  logic          serviced_i,
  input  logic          term_i,
  output logic [IW-1:0] next_idx_o,
  output logic          stop_o
);
  logic last;

  assign last = (idx_i == IW'(N_DEV - 1));

  always_comb begin
    if (serviced_i && disc_i == DISC_PRIO) begin
      // Priority: every finished service returns to the first device.
      next_idx_o = '0;
      stop_o     = term_i;
    end else begin
      // Round robin, or a device that was not ready: advance and wrap.
      next_idx_o = last ? '0 : idx_i + IW'(1);
      stop_o     = last && term_i;
    end
  end
endmodule

// File: rtl/pscan_fsm.sv
module pscan_fsm
  import pscan_pkg::*;
#(
  parameter int N_DEV = 3,
  localparam int IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [N_DEV-1:0] rdy_i,
  input  logic             done_i,
  input  logic             term_req_i,
  input  logic [IW-1:0]    next_idx_i,
  input  logic             stop_i,
  output logic [IW-1:0]    idx_o,
  output pscan_disc_e      disc_o,
  output logic             serviced_o,
  output logic             term_o,
  output logic [N_DEV-1:0] grant_o,
  output logic             finished_o
);
  pscan_state_e     st_q;
  logic [IW-1:0]    idx_q;
  pscan_disc_e      disc_q;
  logic             term_q;
  logic [N_DEV-1:0] grant_q;
  logic             fin_q;
  logic             term_eff;

  assign term_eff   = term_q | term_req_i;
  assign idx_o      = idx_q;
  assign disc_o     = disc_q;
  assign serviced_o = (st_q == ST_SERVE);
  assign term_o     = term_eff;
  assign grant_o    = grant_q;
  assign finished_o = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      disc_q  <= DISC_PRIO;
      term_q  <= 1'b0;
      grant_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_SCAN;
            idx_q  <= '0;
            disc_q <= pscan_disc_e'(mode_i);
            term_q <= 1'b0;
            fin_q  <= 1'b0;
          end
        end
        ST_SCAN: begin
          term_q <= term_eff;
          if (rdy_i[idx_q]) begin
            st_q    <= ST_SERVE;
            grant_q <= N_DEV'(1) << idx_q;
          end else if (stop_i) begin
            st_q  <= ST_IDLE;
            fin_q <= 1'b1;
          end else begin
            idx_q <= next_idx_i;
          end
        end
        ST_SERVE: begin
          term_q <= term_eff;
          if (done_i) begin
            grant_q <= '0;
            if (stop_i) begin
              st_q  <= ST_IDLE;
              fin_q <= 1'b1;
            end else begin
              st_q  <= ST_SCAN;
              idx_q <= next_idx_i;
            end
          end
        end
        default: begin
          st_q    <= ST_IDLE;
          grant_q <= '0;
        end
      endcase
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R3
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && !done_i) |=> (grant_q == $past(grant_q))); // R3
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && $past(grant_q) == '0) |-> (($past(rdy_i) & grant_q) != '0)); // R2
  AST_FIN_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (grant_q == '0)); // R7
  AST_PRIO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERVE && done_i && disc_q == DISC_PRIO && !term_eff)
      |=> (st_q == ST_SCAN && idx_q == '0)); // R5
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(disc_q)); // R10
endmodule

// File: rtl/poll_sched3.sv
module poll_sched3
  import pscan_pkg::*;
#(
  parameter int N_DEV   = 3,
  parameter int STAT_W  = 8,
  parameter int RDY_BIT = 5,
  localparam int IW     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode,
  input  logic [N_DEV*STAT_W-1:0] dev_status,
  input  logic                    svc_done,
  input  logic                    term_req,
  output logic [N_DEV-1:0]        grant,
  output logic                    finished
);
  logic [N_DEV-1:0] rdy;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    next_idx;
  logic             stop;
  logic             serviced;
  logic             term_eff;
  pscan_disc_e      disc;

  pscan_ready_extract #(.N_DEV(N_DEV), .STAT_W(STAT_W), .RDY_BIT(RDY_BIT)) u_rdy (
    .status_i (dev_status),
    .rdy_o    (rdy)
  );

  pscan_step #(.N_DEV(N_DEV)) u_step (
    .idx_i      (idx),
    .disc_i     (disc),
    .serviced_i (serviced),
    .term_i     (term_eff),
    .next_idx_o (next_idx),
    .stop_o     (stop)
  );

  pscan_fsm #(.N_DEV(N_DEV)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .mode_i     (mode),
    .rdy_i      (rdy),
    .done_i     (svc_done),
    .term_req_i (term_req),
    .next_idx_i (next_idx),
    .stop_i     (stop),
    .idx_o      (idx),
    .disc_o     (disc),
    .serviced_o (serviced),
    .term_o     (term_eff),
    .grant_o    (grant),
    .finished_o (finished)
  );

  AST_IDLE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !start) |=> finished); // R12
endmodule

// File: tb/tb_poll_sched3.sv
module tb_poll_sched3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [23:0] dev_status = '0;
  logic        svc_done = 1'b0;
  logic        term_req = 1'b0;
  logic [2:0]  grant;
  logic        finished;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  poll_sched3 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dev_status(dev_status), .svc_done(svc_done), .term_req(term_req),
    .grant(grant), .finished(finished)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_stat(input logic [7:0] s1, input logic [7:0] s2, input logic [7:0] s3);
    dev_status = {s3, s2, s1};
  endtask

  task automatic start_run(input logic m);
    mode = m; start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic pulse_done();
    svc_done = 1'b1; tick(); svc_done = 1'b0;
  endtask

  task automatic wait_grant(input logic [2:0] exp, input string req);
    for (int i = 0; i < 20; i++) begin
      if (grant != 3'b000) break;
      tick();
    end
    check(grant == exp, req, grant, exp);
  endtask

  task automatic finish_run();
    term_req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (finished) break;
      if (grant != 3'b000) pulse_done();
      else tick();
    end
    term_req = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    bit ok = 1;
    set_stat(8'h20, 8'h20, 8'h20);
    for (int i = 0; i < 6; i++) begin
      tick();
      if (grant != 3'b000 || finished) ok = 0;
    end
    check(ok, "R1 idle after reset", {finished, grant}, 0);
  endtask

  task automatic t_ready_bit();
    bit ok = 1;
    set_stat(8'hDF, 8'hDF, 8'hDF);
    start_run(1'b0);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (grant != 3'b000) ok = 0;
    end
    check(ok, "R2 bits other than 5 ignored", grant, 0);
    set_stat(8'hDF, 8'h20, 8'hDF);
    wait_grant(3'b010, "R2 bit 5 makes device ready");
    finish_run();
  endtask

  task automatic t_prio();
    bit ok = 1;
    set_stat(8'h20, 8'h20, 8'h20);
    start_run(1'b0);
    wait_grant(3'b001, "R4 device 1 examined first");
    for (int i = 0; i < 8; i++) begin
      tick();
      if (grant != 3'b001) ok = 0;
    end
    check(ok, "R3 grant held until done", grant, 3'b001);
    set_stat(8'h00, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b010, "R4 device 2 after device 1");
    set_stat(8'h20, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b001, "R5 priority restarts at device 1");
    finish_run();
  endtask

  task automatic t_rr();
    set_stat(8'h20, 8'h20, 8'h20);
    start_run(1'b1);
    wait_grant(3'b001, "R6 rr first grant");
    set_stat(8'h00, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b010, "R6 rr device 2");
    set_stat(8'h20, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b100, "R6 rr continues to device 3");
    pulse_done();
    wait_grant(3'b001, "R6 rr wraps to device 1");
    finish_run();
  endtask

  task automatic t_prio_term();
    set_stat(8'h20, 8'h20, 8'h20);
    start_run(1'b0);
    wait_grant(3'b001, "R7 setup grant");
    term_req = 1'b1;
    pulse_done();
    term_req = 1'b0;
    check(finished == 1'b1 && grant == 3'b000, "R7 priority stops after service",
          {finished, grant}, 4'h8);
    set_stat(8'h00, 8'h00, 8'h00);
    start_run(1'b0);
    term_req = 1'b1; tick(); term_req = 1'b0;
    for (int i = 0; i < 6; i++) if (!finished) tick();
    check(finished == 1'b1, "R7 priority stops at end of idle pass", finished, 1);
  endtask

  task automatic t_rr_term();
    set_stat(8'h20, 8'h20, 8'h20);
    start_run(1'b1);
    wait_grant(3'b001, "R8 setup grant");
    term_req = 1'b1;
    pulse_done();
    term_req = 1'b0;
    wait_grant(3'b010, "R8 rr serves device 2 after request");
    pulse_done();
    wait_grant(3'b100, "R8 rr serves device 3 after request");
    pulse_done();
    check(finished == 1'b1 && grant == 3'b000, "R8 rr stops after device 3",
          {finished, grant}, 4'h8);
  endtask

  task automatic t_idle_repeat();
    bit ok = 1;
    set_stat(8'h00, 8'h00, 8'h00);
    start_run(1'b0);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (grant != 3'b000 || finished) ok = 0;
    end
    check(ok, "R9 empty scan keeps running", {finished, grant}, 0);
    set_stat(8'h00, 8'h00, 8'h20);
    wait_grant(3'b100, "R9 later ready is found");
    finish_run();
  endtask

  task automatic t_mode_busy();
    set_stat(8'h20, 8'h20, 8'h20);
    start_run(1'b0);
    wait_grant(3'b001, "R10 setup grant");
    mode = 1'b1;
    set_stat(8'h00, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b010, "R10 device 2");
    set_stat(8'h20, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b001, "R10 mode change during run ignored");
    finish_run();
  endtask

  task automatic t_ignored();
    bit ok = 1;
    set_stat(8'h00, 8'h00, 8'h00);
    start_run(1'b1);
    tick();
    pulse_done();
    tick();
    check(grant == 3'b000 && !finished, "R11 done without grant ignored", grant, 0);
    set_stat(8'h00, 8'h20, 8'h00);
    wait_grant(3'b010, "R11 grant after stray done");
    start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (grant != 3'b010) ok = 0;
    end
    check(ok, "R11 start while busy ignored", grant, 3'b010);
    finish_run();
  endtask

  task automatic t_restart();
    bit ok = 1;
    set_stat(8'h20, 8'h20, 8'h20);
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!finished) ok = 0;
    end
    check(ok, "R12 finished holds while idle", finished, 1);
    start_run(1'b0);
    check(finished == 1'b0, "R12 start clears finished", finished, 0);
    wait_grant(3'b001, "R12 new run grants");
    set_stat(8'h00, 8'h20, 8'h20);
    pulse_done();
    wait_grant(3'b010, "R12 termination cleared by start");
    finish_run();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_ready_bit();
    t_prio();
    t_rr();
    t_prio_term();
    t_rr_term();
    t_idle_repeat();
    t_mode_busy();
    t_ignored();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule